// File: doc/BRIEF.md
# Supply Droop Supervisor and Reset Sequencer

This block turns three pre-filtered supply comparator flags into the power-related controls of an embedded processor. The flags are ordered: the warning flag trips first as the supply sags, then the minimum-operating flag, then the battery-switch flag. Each level adds a stronger response. At the warning level the processor keeps running and may be interrupted. At the minimum level the processor is held in reset and its external bus strobes are parked high. At the battery level the backup cell is selected.

On the warning level the block raises one interrupt request per downward crossing, provided software has enabled it, and presents the fixed vector address 002Bh. Software clears the request with a one-cycle acknowledge. When the supply climbs back above the minimum level, reset is not released at once. A down-counter holds it for a fixed number of clocks, 21504 by default, and the count starts over if the supply dips again before it finishes. The analog comparators and their filtering sit outside the block. The block has no data stream, so all pins are plain level controls with no handshake.

Top module: `pwr_fail_seq`

## Requirements
- R1: While `rst_n` is low and right after it rises, `cpu_reset` is 1, `warn_irq` is 0 and `batt_sel` is 0. Reset is then released only after the normal recovery count, as in R8.
- R2: A clock edge that samples `below_warn` high after it was sampled low at the previous edge sets `warn_irq` from that edge on, if `warn_int_en` is 1 at that edge. If `warn_int_en` is 0, no request is made, and the crossing is not remembered for later.
- R3: An edge that samples `warn_ack` high clears `warn_irq`. If a new crossing per R2 is seen at the same edge, the set wins.
- R4: `below_warn` staying high never raises `warn_irq` again. A new request needs `below_warn` to be sampled low, and then high again.
- R5: `warn_vec` always equals 16'h002B.
- R6: With only `below_warn` high (`below_min` low) and no recovery count running, `cpu_reset` stays 0.
- R7: Every edge that samples `below_min` high makes `cpu_reset` 1 after that edge.
- R8: After the last edge that samples `below_min` high, `cpu_reset` stays 1 until the DELAY-th following edge that samples it low, and is 0 after that edge. A new high sample restarts the full count.
- R9: While `cpu_reset` is 1, every bit of `ce_n_out` is 1 and `rw_n_out` is 1. Otherwise they equal `ce_n_in` and `rw_n_in`, with no delay.
- R10: `batt_sel` equals the value of `below_batt` sampled at the previous edge, one cycle later in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| below_warn | input | 1 | Supply is below the warning threshold |
| below_min | input | 1 | Supply is below the minimum operating threshold |
| below_batt | input | 1 | Supply is below the battery switch threshold |
| warn_int_en | input | 1 | Enables the warning interrupt |
| warn_ack | input | 1 | Clears a pending warning request |
| ce_n_in | input | NUM_CE | Decoded chip enables from the core, active low |
| rw_n_in | input | 1 | Read/write strobe from the core |
| warn_irq | output | 1 | Pending warning interrupt request |
| warn_vec | output | VEC_W | Warning interrupt vector address |
| cpu_reset | output | 1 | Internal processor reset, active high |
| ce_n_out | output | NUM_CE | Chip enables, forced to 1 during reset |
| rw_n_out | output | 1 | Read/write strobe, forced to 1 during reset |
| batt_sel | output | 1 | Selects the backup cell as the power source |

## Verification
The bench builds the block with DELAY = 12 and NUM_CE = 3. With this short count, a full recovery window fits inside a few dozen cycles. The exact release edge, and a restart caused by a dip partway through the count, can therefore be hit many times. This happens both in directed scenes and in a long random phase in which the three flags follow their required ordering. Three chip enables make the per-bit override of R9 visible on more than one lane.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  // Comparator flags, ordered from the weakest to the strongest droop.
  typedef struct packed {
    logic batt;
    logic min;
    logic warn;
  } supply_flags_t;

  localparam logic [15:0] WARN_VECTOR = 16'h002B;
endpackage

// File: rtl/pfs_warn_irq.sv
module pfs_warn_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic below_warn,
  input  logic int_en,
  input  logic ack,
  output logic irq
);
  logic prev_q;
  logic crossing;

  assign crossing = below_warn & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      prev_q <= below_warn;
      if (crossing && int_en)
        irq <= 1'b1;
      else if (ack)
        irq <= 1'b0;
    end
  end

  // R2
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && below_warn && !$past(below_warn) && int_en) |=> irq);

  // R3
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ack && !(below_warn && !$past(below_warn) && int_en)) |=> !irq);

  // R4
  irq_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !irq && below_warn && $past(below_warn)) |=> !irq);
endmodule

// File: rtl/pfs_rst_timer.sv
module pfs_rst_timer #(
  parameter int DELAY = 21504
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_min,
  output logic hold_reset
);
  localparam int CNT_W = $clog2(DELAY + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= LOAD;
    else if (below_min)
      cnt_q <= LOAD;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign hold_reset = (cnt_q != '0);

  // R7
  min_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    below_min |=> hold_reset);

  // R8
  release_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!below_min && !hold_reset) |=> !hold_reset);
endmodule

// File: rtl/pfs_batt_sel.sv
module pfs_batt_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic below_batt,
  output logic batt_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      batt_sel <= 1'b0;
    else
      batt_sel <= below_batt;
  end

  // R10
  batt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (batt_sel == $past(below_batt)));
endmodule

// File: rtl/pwr_fail_seq.sv
module pwr_fail_seq
  import pfs_pkg::*;
#(
  parameter int DELAY  = 21504,
  parameter int NUM_CE = 4,
  parameter int VEC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              below_warn,
  input  logic              below_min,
  input  logic              below_batt,
  input  logic              warn_int_en,
  input  logic              warn_ack,
  input  logic [NUM_CE-1:0] ce_n_in,
  input  logic              rw_n_in,
  output logic              warn_irq,
  output logic [VEC_W-1:0]  warn_vec,
  output logic              cpu_reset,
  output logic [NUM_CE-1:0] ce_n_out,
  output logic              rw_n_out,
  output logic              batt_sel
);
  supply_flags_t flags;

  assign flags = '{batt: below_batt, min: below_min, warn: below_warn};

  pfs_warn_irq u_warn (
    .clk        (clk),
    .rst_n      (rst_n),
    .below_warn (flags.warn),
    .int_en     (warn_int_en),
    .ack        (warn_ack),
    .irq        (warn_irq)
  );

  pfs_rst_timer #(.DELAY(DELAY)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .below_min  (flags.min),
    .hold_reset (cpu_reset)
  );

  pfs_batt_sel u_batt (
    .clk        (clk),
    .rst_n      (rst_n),
    .below_batt (flags.batt),
    .batt_sel   (batt_sel)
  );

  assign warn_vec = VEC_W'(WARN_VECTOR);

  // Per-lane override: parking a strobe high makes it inactive.
  for (genvar i = 0; i < NUM_CE; i++) begin : g_ce
    assign ce_n_out[i] = ce_n_in[i] | cpu_reset;
  end
  assign rw_n_out = rw_n_in | cpu_reset;

  // R9
  bus_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset |-> ((&ce_n_out) && rw_n_out));

  // R6
  warn_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (below_warn && !below_min && !cpu_reset) |=> !cpu_reset);
endmodule

// File: tb/pwr_fail_seq_bench.sv
module pwr_fail_seq_bench;
  localparam int D  = 12;
  localparam int NC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bw = 0, bm = 0, bb = 0, en = 0, ack = 0, rw_in = 1;
  logic [NC-1:0] ce_in = '1;
  logic irq, rst_o, rw_o, bsel;
  logic [15:0] vec;
  logic [NC-1:0] ce_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_fail_seq #(.DELAY(D), .NUM_CE(NC), .VEC_W(16)) u_pwr_fail_seq (
    .clk(clk), .rst_n(rst_n), .below_warn(bw), .below_min(bm), .below_batt(bb),
    .warn_int_en(en), .warn_ack(ack), .ce_n_in(ce_in), .rw_n_in(rw_in),
    .warn_irq(irq), .warn_vec(vec), .cpu_reset(rst_o), .ce_n_out(ce_o),
    .rw_n_out(rw_o), .batt_sel(bsel)
  );

  // Behavioural reference
  int m_cnt;
  bit m_irq, m_prev, m_batt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = D; m_irq = 0; m_prev = 0; m_batt = 0;
    end else begin
      if (bw && !m_prev && en) m_irq = 1;
      else if (ack) m_irq = 0;
      m_prev = bw;
      if (bm) m_cnt = D;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_batt = bb;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic er;
      er = (m_cnt != 0);
      chk("R2 R3 R4 warn_irq", 32'(irq), 32'(m_irq));
      chk("R5 warn_vec", 32'(vec), 32'h2B);
      chk("R7 R8 cpu_reset", 32'(rst_o), 32'(er));
      chk("R9 ce_n_out", 32'(ce_o), er ? 32'((1 << NC) - 1) : 32'(ce_in));
      chk("R9 rw_n_out", 32'(rw_o), er ? 32'd1 : 32'(rw_in));
      chk("R10 batt_sel", 32'(bsel), 32'(m_batt));
    end
  end

  task automatic go(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic flags(input logic w, input logic m, input logic b, input int n);
    bw = w; bm = m; bb = b;
    go(n);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    go(3);
    #1;
    chk("R1 reset held during rst_n", 32'(rst_o), 32'd1);
    chk("R1 irq low during rst_n", 32'(irq), 32'd0);
    rst_n = 1;
    go(1);
    chk("R1 reset after release", 32'(rst_o), 32'd1);
    go(D);
    chk("R1 reset released after count", 32'(rst_o), 32'd0);

    // Warning with interrupt disabled: no request
    en = 0; ce_in = 3'b010; rw_in = 0;
    flags(1, 0, 0, 4);
    chk("R2 disabled crossing ignored", 32'(irq), 32'd0);
    chk("R6 warn only keeps running", 32'(rst_o), 32'd0);
    en = 1; go(3);
    chk("R4 late enable no request", 32'(irq), 32'd0);
    flags(0, 0, 0, 2);
    flags(1, 0, 0, 1);
    chk("R2 request on crossing", 32'(irq), 32'd1);
    ack = 1; go(1); ack = 0; go(4);
    chk("R3 R4 cleared and not re-raised", 32'(irq), 32'd0);

    // Ack and crossing together: set wins
    flags(0, 0, 0, 1);
    ack = 1; flags(1, 0, 0, 1); ack = 0;
    chk("R3 set wins over ack", 32'(irq), 32'd1);
    ack = 1; go(1); ack = 0;

    // Minimum level and exact release
    flags(1, 1, 0, 3);
    chk("R7 reset on minimum", 32'(rst_o), 32'd1);
    chk("R9 strobes parked", 32'(ce_o), 32'h7);
    flags(1, 0, 0, D - 1);
    chk("R8 still held one before release", 32'(rst_o), 32'd1);
    go(1);
    chk("R8 released on count", 32'(rst_o), 32'd0);

    // Restart on dip mid-count
    flags(1, 1, 0, 1);
    flags(1, 0, 0, D / 2);
    flags(1, 1, 0, 1);
    flags(1, 0, 0, D - 1);
    chk("R8 restart holds full count", 32'(rst_o), 32'd1);
    go(1);
    chk("R8 restart release", 32'(rst_o), 32'd0);

    // Battery select both directions
    flags(1, 1, 1, 1);
    chk("R10 battery selected", 32'(bsel), 32'd1);
    flags(1, 1, 0, 1);
    chk("R10 battery released", 32'(bsel), 32'd0);
    flags(0, 0, 0, D + 2);

    // Random phase with ordered flags
    for (int i = 0; i < 3000; i++) begin
      int lvl;
      lvl = $urandom_range(0, 9);
      lvl = (lvl < 5) ? 0 : (lvl < 7) ? 1 : (lvl < 9) ? 2 : 3;
      en = ($urandom_range(0, 3) != 0);
      ack = ($urandom_range(0, 4) == 0);
      ce_in = NC'($urandom);
      rw_in = 1'($urandom);
      flags(lvl >= 1, lvl >= 2, lvl >= 3, $urandom_range(1, D + 3));
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_run();
  end
endmodule